// File: doc/BRIEF.md
# Bit-Banged Serial EEPROM Slave Model

This block models the slave side of a two-wire serial EEPROM holding 256 read-only bytes. It does not sit on open-drain pads. Each time the surrounding logic has a new pair of clock and data line levels, it presents them together with a one-cycle strobe. The block compares them with the levels it stored at the previous strobe. From that comparison it finds start and stop conditions and rising clock edges. It then walks through one simplified transaction: an 8-bit command, an acknowledge, an 8-bit word address, and a second acknowledge.

During the address phase of a read command, each rising edge replaces the stored data level with the top bit of the byte fetched at the end of the previous transaction. The byte at the newly received address is looked up only when the last address bit arrives. That byte is therefore returned by the next read transaction. The stored data level, including any low level the slave forces, is brought out for readback. The contents are a computed image chosen by parameters, so no table is stored.

The control is a three-state phase machine with a bit index and a separate acknowledge-pending flag. The states are ST_IDLE (waiting for a start), ST_CMD (receiving command bits) and ST_ADDR (receiving address bits). The transitions are:
- start: from any state to ST_CMD.
- command complete: ST_CMD to ST_ADDR on the eighth command bit.
- address complete: ST_ADDR to ST_IDLE on the eighth address bit.

A stop condition leaves the state unchanged. An acknowledge rise consumes a clock edge without moving the state.

Top module: `i2cee_slave`

## Requirements
- R1: After reset the stored clock and data levels are both 1, so `sda_rd` reads 1. The phase is ST_IDLE, no acknowledge is pending, and the command, address and fetched-data registers are zero.
- R2: A start is a strobe where the clock line is high both at the stored and the new sample and the data line falls from 1 to 0. From any state it enters ST_CMD with the bit index at zero and the command cleared. A pending acknowledge is kept.
- R3: A stop is a strobe where the clock line is high at both samples and the data line rises from 0 to 1. It changes no phase, index or register. Only the stored levels take the new values, so `sda_rd` reads 1.
- R4: In ST_IDLE with no acknowledge pending, every strobe other than a start leaves the phase and the registers unchanged. The stored data level follows the input.
- R5: A bit is sampled only on a rising clock edge (stored clock 0, new clock 1) where the new data level equals the stored one. A rising edge on which the data level also changes shifts nothing and advances nothing, unless an acknowledge is pending.
- R6: In ST_CMD, eight sampled bits enter the command register, the first one ending up as bit 7. The eighth bit moves the phase to ST_ADDR and sets acknowledge-pending.
- R7: On any rising edge while acknowledge is pending, the stored data level becomes 0 whatever the input is. The flag then clears, and no bit is consumed.
- R8: In ST_ADDR, each sampled bit enters the address register, the first one ending up as bit 7. When command bit 0 is 1 (read), the stored data level on that edge is bit 7 of the fetched-data register, and the register then shifts left with zero fill.
- R9: When command bit 0 is 0 (write), the stored data level during the address phase is the level the master drives.
- R10: The eighth address bit loads the fetched-data register with the image byte at the completed address, sets acknowledge-pending and returns to ST_IDLE. A read transaction therefore returns the byte addressed by the transaction before it.
- R11: The image byte at address a is ((a × 0x1D + 0x5A) mod 256) XOR (a with its two nibbles swapped), with the default parameters.
- R12: While `pin_vld` is 0, nothing changes, whatever the pin inputs do.
- R13: `sda_rd` shows the stored data level. It reflects a strobe from the first clock edge at which `pin_vld` is sampled high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_vld | input | 1 | Strobe: new line levels are present on `pin_scl` and `pin_sda` |
| pin_scl | input | 1 | Sampled clock line level |
| pin_sda | input | 1 | Sampled data line level driven by the master |
| sda_rd | output | 1 | Stored data line level, including levels forced by the slave |

## Verification
The only visible output is the stored data level, so a wrong internal state shows up in different ways.
- A bit index that miscounts shows at the very rising edge where the acknowledge should or should not appear: the line reads 0 one bit early, or 1 where 0 was expected.
- A wrong address or wrong fetched data stays hidden until the following read transaction, up to about fifty strobes later, when the returned bits differ.
- A lost or doubled acknowledge flag changes the level seen on the next rise.

A behavioural model in the bench compares the readback after every clock, so any divergence is reported in the cycle where it first reaches the port.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

    localparam int CMD_BITS = 8;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CMD  = 2'd1,
        ST_ADDR = 2'd2
    } phase_e;

    typedef enum logic [2:0] {
        EV_NONE      = 3'd0,
        EV_START     = 3'd1,
        EV_STOP      = 3'd2,
        EV_RISE      = 3'd3,
        EV_RISE_SKEW = 3'd4,
        EV_OTHER     = 3'd5
    } pin_ev_e;

endpackage

// File: rtl/i2cee_pin_track.sv
module i2cee_pin_track
    import i2cee_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    vld,
    input  logic    scl_i,
    input  logic    sda_i,
    input  logic    sda_next,
    output pin_ev_e ev,
    output logic    sda_q
);

    logic scl_q;

    // stored line levels, updated on every strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else if (vld) begin
            scl_q <= scl_i;
            sda_q <= sda_next;
        end
    end

    // classify the new sample against the stored one
    always_comb begin
        ev = EV_NONE;
        if (vld) begin
            if (scl_q && scl_i && (sda_q != sda_i)) begin
                ev = sda_i ? EV_STOP : EV_START;
            end else if (!scl_q && scl_i) begin
                ev = (sda_q == sda_i) ? EV_RISE : EV_RISE_SKEW;
            end else begin
                ev = EV_OTHER;
            end
        end
    end

endmodule

// File: rtl/i2cee_image_rom.sv
module i2cee_image_rom #(
    parameter int             AW   = 8,
    parameter int             DW   = 8,
    parameter logic [DW-1:0]  SEED = 8'h5A,
    parameter logic [DW-1:0]  STEP = 8'h1D,
    parameter bit             MIX  = 1'b1
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);

    localparam int HALF = AW / 2;

    logic [DW-1:0] base;
    assign base = DW'(addr) * STEP + SEED;

    generate
        if (MIX) begin : g_mix
            logic [AW-1:0] swapped;
            assign swapped = {addr[HALF-1:0], addr[AW-1:HALF]};
            assign data    = base ^ DW'(swapped);
        end else begin : g_plain
            assign data = base;
        end
    endgenerate

endmodule

// File: rtl/i2cee_fsm.sv
module i2cee_fsm
    import i2cee_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 8,
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pin_ev_e          ev,
    input  logic             sda_i,
    input  logic [DW-1:0]    rom_data,
    output logic [AW-1:0]    rom_addr,
    output logic             sda_next,
    output phase_e           phase_q,
    output logic [IDX_W-1:0] idx_q,
    output logic [CMD_BITS-1:0] cmd_q,
    output logic             ack_q
);

    localparam logic [IDX_W-1:0] CMD_LAST  = IDX_W'(CMD_BITS - 1);
    localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(AW - 1);

    phase_e              phase_d;
    logic [IDX_W-1:0]    idx_d;
    logic [CMD_BITS-1:0] cmd_d;
    logic [AW-1:0]       addr_q, addr_d;
    logic [DW-1:0]       data_q, data_d;
    logic                ack_d;
    logic                rise_any;

    assign rise_any = (ev == EV_RISE) || (ev == EV_RISE_SKEW);
    assign rom_addr = {addr_q[AW-2:0], sda_i};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= ST_IDLE;
            idx_q   <= '0;
            cmd_q   <= '0;
            addr_q  <= '0;
            data_q  <= '0;
            ack_q   <= 1'b0;
        end else begin
            phase_q <= phase_d;
            idx_q   <= idx_d;
            cmd_q   <= cmd_d;
            addr_q  <= addr_d;
            data_q  <= data_d;
            ack_q   <= ack_d;
        end
    end

    // next state and forced data level
    always_comb begin
        phase_d  = phase_q;
        idx_d    = idx_q;
        cmd_d    = cmd_q;
        addr_d   = addr_q;
        data_d   = data_q;
        ack_d    = ack_q;
        sda_next = sda_i;

        if (ev == EV_START) begin
            phase_d = ST_CMD;
            idx_d   = '0;
            cmd_d   = '0;
        end else if (rise_any && ((phase_q != ST_IDLE) || ack_q)) begin
            if (ack_q) begin
                sda_next = 1'b0;
                ack_d    = 1'b0;
            end else if (ev == EV_RISE) begin
                unique case (phase_q)
                    ST_CMD: begin
                        cmd_d = {cmd_q[CMD_BITS-2:0], sda_i};
                        if (idx_q == CMD_LAST) begin
                            phase_d = ST_ADDR;
                            idx_d   = '0;
                            ack_d   = 1'b1;
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end
                    ST_ADDR: begin
                        if (cmd_q[0]) begin
                            sda_next = data_q[DW-1];
                        end
                        addr_d = rom_addr;
                        data_d = {data_q[DW-2:0], 1'b0};
                        if (idx_q == ADDR_LAST) begin
                            data_d  = rom_data;
                            ack_d   = 1'b1;
                            phase_d = ST_IDLE;
                            idx_d   = '0;
                        end else begin
                            idx_d = idx_q + 1'b1;
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/i2cee_slave.sv
module i2cee_slave
    import i2cee_pkg::*;
#(
    parameter int             AW       = 8,
    parameter int             DW       = 8,
    parameter logic [DW-1:0]  IMG_SEED = 8'h5A,
    parameter logic [DW-1:0]  IMG_STEP = 8'h1D,
    parameter bit             IMG_MIX  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_vld,
    input  logic pin_scl,
    input  logic pin_sda,
    output logic sda_rd
);

    localparam int SPAN  = (CMD_BITS > AW) ? CMD_BITS : AW;
    localparam int IDX_W = $clog2(SPAN);

    pin_ev_e             ev_w;
    phase_e              phase_w;
    logic [IDX_W-1:0]    idx_w;
    logic [CMD_BITS-1:0] cmd_w;
    logic                ack_w;
    logic                sda_next_w;
    logic [AW-1:0]       rom_addr_w;
    logic [DW-1:0]       rom_data_w;

    i2cee_pin_track u_pins (
        .clk      (clk),
        .rst_n    (rst_n),
        .vld      (pin_vld),
        .scl_i    (pin_scl),
        .sda_i    (pin_sda),
        .sda_next (sda_next_w),
        .ev       (ev_w),
        .sda_q    (sda_rd)
    );

    i2cee_image_rom #(
        .AW   (AW),
        .DW   (DW),
        .SEED (IMG_SEED),
        .STEP (IMG_STEP),
        .MIX  (IMG_MIX)
    ) u_rom (
        .addr (rom_addr_w),
        .data (rom_data_w)
    );

    i2cee_fsm #(
        .AW    (AW),
        .DW    (DW),
        .IDX_W (IDX_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .ev       (ev_w),
        .sda_i    (pin_sda),
        .rom_data (rom_data_w),
        .rom_addr (rom_addr_w),
        .sda_next (sda_next_w),
        .phase_q  (phase_w),
        .idx_q    (idx_w),
        .cmd_q    (cmd_w),
        .ack_q    (ack_w)
    );

endmodule

// File: rtl/i2cee_chk.sv
module i2cee_chk
    import i2cee_pkg::*;
#(
    parameter int AW    = 8,
    parameter int IDX_W = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                pin_vld,
    input logic                sda_rd,
    input pin_ev_e             ev,
    input phase_e              phase,
    input logic [IDX_W-1:0]    idx,
    input logic [CMD_BITS-1:0] cmd,
    input logic                ack
);

    localparam logic [IDX_W-1:0] CMD_LAST  = IDX_W'(CMD_BITS - 1);
    localparam logic [IDX_W-1:0] ADDR_LAST = IDX_W'(AW - 1);

    p_start_enters_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev == EV_START) |=> (phase == ST_CMD && idx == '0 && cmd == '0));

    p_idle_ignores_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_IDLE && !ack && ev != EV_START) |=> (phase == ST_IDLE && !ack && $stable(cmd)));

    p_skew_no_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack && ev == EV_RISE_SKEW) |=> ($stable(cmd) && $stable(idx) && $stable(phase)));

    p_cmd_done_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_CMD && idx == CMD_LAST && !ack && ev == EV_RISE) |=> (phase == ST_ADDR && ack));

    p_ack_forces_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && (ev == EV_RISE || ev == EV_RISE_SKEW)) |=> (!sda_rd && !ack));

    p_addr_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == ST_ADDR && idx == ADDR_LAST && !ack && ev == EV_RISE) |=> (phase == ST_IDLE && ack));

    p_hold_without_strobe_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!pin_vld) |=> ($stable(sda_rd) && $stable(phase) && $stable(ack)));

endmodule

bind i2cee_slave i2cee_chk #(
    .AW    (AW),
    .IDX_W (IDX_W)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .pin_vld (pin_vld),
    .sda_rd  (sda_rd),
    .ev      (ev_w),
    .phase   (phase_w),
    .idx     (idx_w),
    .cmd     (cmd_w),
    .ack     (ack_w)
);

// File: tb/i2cee_slave_tb_top.sv
`timescale 1ns/1ps
module i2cee_slave_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin_vld = 1'b0;
    logic pin_scl = 1'b1;
    logic pin_sda = 1'b1;
    logic sda_rd;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // behavioural reference state
    int m_tick = 0, m_cmd = 0, m_addr = 0, m_data = 0, m_ack = 0;
    int m_scl = 1, m_sda = 1;
    bit cs = 1'b1, cd = 1'b1;

    always #2 clk = ~clk;

    i2cee_slave dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_vld (pin_vld),
        .pin_scl (pin_scl),
        .pin_sda (pin_sda),
        .sda_rd  (sda_rd)
    );

    // R11 expected image byte
    function automatic int exp_img(int a);
        int b;
        b = (a * 29 + 90) & 255;
        return b ^ (((a & 15) << 4) | ((a >> 4) & 15));
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step(int s, int d);
        int dd;
        dd = d;
        if (m_scl != 0 && s != 0 && m_sda != d) begin
            if (d == 0) begin
                m_tick = 1;
                m_cmd  = 0;
            end
        end else if (m_tick == 0 && m_ack == 0) begin
        end else if (m_scl == 0 && s != 0) begin
            if (m_ack != 0) begin
                dd = 0;
                m_ack = 0;
            end else if (m_sda == d) begin
                if (m_tick < 9) begin
                    m_cmd = ((m_cmd << 1) | d) & 255;
                    m_tick++;
                    if (m_tick == 9) m_ack = 1;
                end else if (m_tick < 17) begin
                    if ((m_cmd & 1) != 0) dd = (m_data >> 7) & 1;
                    m_addr = ((m_addr << 1) | d) & 255;
                    m_tick++;
                    m_data = (m_data << 1) & 255;
                    if (m_tick == 17) begin
                        m_data = exp_img(m_addr);
                        m_ack  = 1;
                        m_tick = 0;
                    end
                end
            end
        end
        m_scl = s;
        m_sda = dd;
    endtask

    // R13: readback compared with the model after every clock
    always begin
        @(posedge clk);
        #1;
        if (rst_n && !done) chk("R13 readback vs model", int'(sda_rd), m_sda);
    end

    task automatic upd(bit s, bit d);
        @(negedge clk);
        pin_vld = 1'b1;
        pin_scl = s;
        pin_sda = d;
        model_step(int'(s), int'(d));
        @(negedge clk);
        pin_vld = 1'b0;
    endtask

    task automatic send_bit(bit b, output bit r);
        upd(1'b0, b);
        upd(1'b1, b);
        r = sda_rd;
        upd(1'b0, b);
    endtask

    task automatic do_start();
        upd(1'b0, 1'b1);
        upd(1'b1, 1'b1);
        upd(1'b1, 1'b0);
    endtask

    task automatic do_stop();
        upd(1'b0, 1'b0);
        upd(1'b1, 1'b0);
        upd(1'b1, 1'b1);
    endtask

    task automatic xfer(input logic [7:0] cmd, input logic [7:0] adr, input int skew_at,
                        output bit last_cmd, output bit ack1,
                        output logic [7:0] rd, output bit ack2);
        bit r;
        do_start();
        for (int i = 0; i < 8; i++) begin
            if (i == skew_at) begin
                upd(1'b0, 1'b0);
                upd(1'b1, 1'b1);
                upd(1'b0, 1'b1);
            end
            send_bit(cmd[7-i], r);
            if (i == 7) last_cmd = r;
        end
        send_bit(1'b1, ack1);
        for (int i = 0; i < 8; i++) begin
            send_bit(adr[7-i], r);
            rd[7-i] = r;
        end
        send_bit(1'b1, ack2);
        do_stop();
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

    initial begin
        bit lc, a1, a2, r;
        logic [7:0] rd;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset readback", int'(sda_rd), 1);

        // R12: pins move without strobe
        pin_scl = 1'b0;
        pin_sda = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 no strobe no change", int'(sda_rd), 1);

        // R4: idle activity ignored, level follows input
        upd(1'b0, 1'b0);
        chk("R4 idle follows input", int'(sda_rd), 0);
        upd(1'b1, 1'b0);
        chk("R4 idle rise ignored", int'(sda_rd), 0);
        upd(1'b1, 1'b1);

        // first read returns the reset data register
        xfer(8'hA1, 8'h3C, -1, lc, a1, rd, a2);
        chk("R6 eighth command bit not acked", int'(lc), 1);
        chk("R7 command ack forced low", int'(a1), 0);
        chk("R8 read of reset data", int'(rd), 0);
        chk("R10 address ack forced low", int'(a2), 0);
        chk("R3 stop leaves line high", int'(sda_rd), 1);

        // R11 / R10: byte fetched previously is returned now
        xfer(8'hA1, 8'h7E, -1, lc, a1, rd, a2);
        chk("R11 image byte at 0x3C", int'(rd), exp_img(8'h3C));
        chk("R7 ack second read", int'(a1), 0);

        // R9: write command, line follows master
        xfer(8'hA0, 8'h55, -1, lc, a1, rd, a2);
        chk("R9 write mode follows master", int'(rd), 8'h55);

        xfer(8'hA1, 8'h00, -1, lc, a1, rd, a2);
        chk("R10 fetch after write command", int'(rd), exp_img(8'h55));

        // R5: skewed rise inside the command phase is not a bit
        xfer(8'hA1, 8'h91, 3, lc, a1, rd, a2);
        chk("R5 skew not counted last bit", int'(lc), 1);
        chk("R5 skew not counted ack", int'(a1), 0);
        chk("R5 data after skew", int'(rd), exp_img(8'h00));

        // R3: stop in the middle of the command keeps counting
        do_start();
        send_bit(1'b1, r);
        send_bit(1'b0, r);
        send_bit(1'b1, r);
        send_bit(1'b0, r);
        do_stop();
        chk("R3 stop readback", int'(sda_rd), 1);
        send_bit(1'b0, r);
        send_bit(1'b0, r);
        send_bit(1'b1, r);
        chk("R3 bit after stop", int'(r), 1);
        send_bit(1'b1, r);
        chk("R3 ack after stop still due", int'(r), 0);
        for (int i = 0; i < 8; i++) send_bit(1'b0, r);
        send_bit(1'b1, r);
        chk("R10 ack after stop sequence", int'(r), 0);

        // R2: restart in mid command restarts the count
        do_start();
        send_bit(1'b1, r);
        send_bit(1'b1, r);
        do_start();
        for (int i = 0; i < 8; i++) begin
            send_bit(((8'hA1 >> (7 - i)) & 1) != 0, r);
        end
        chk("R2 restart count last bit", int'(r), 1);
        send_bit(1'b1, r);
        chk("R2 restart ack position", int'(r), 0);
        for (int i = 0; i < 8; i++) send_bit(1'b1, r);
        send_bit(1'b1, r);
        do_stop();

        // random stress, compared every cycle (R13)
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (($urandom % 4) != 0) begin
                if (($urandom % 2) != 0) cs = ~cs;
                if (($urandom % 6) == 0) cd = ~cd;
                pin_vld = 1'b1;
                pin_scl = cs;
                pin_sda = cd;
                model_step(int'(cs), int'(cd));
            end else begin
                pin_vld = 1'b0;
                pin_scl = ~cs;
                pin_sda = ~cd;
            end
        end
        @(negedge clk);
        pin_vld = 1'b0;
        @(negedge clk);
        chk("R12 final readback", int'(sda_rd), m_sda);
        finish_run();
    end

endmodule